// File: doc/BRIEF.md
# Hardware Error Report Bank

This block holds one 64-bit status word that records a hardware error report. Each report arrives on a one-cycle valid strobe and carries a model-specific code, an architectural code, a severity flag (uncorrected or corrected) and a two-bit threshold health colour. The bank packs these into fixed bit positions. A second report that arrives while a report is still held sets an overflow flag. Whether the new report replaces the held one depends on severity first and health colour second.

Software reads the status word directly. It writes the same word through a write port: a write of zero empties the bank, and any other value only changes the enable flag. A registered request pulse tells the interrupt or exception logic when a serious report has been captured.

Top module: `mc_err_bank`

## Requirements
- R1: After synchronous reset, `status_q` is all zeros and `req_pulse` is 0.
- R2: While the enable flag (bit 60) is 0, a report leaves `status_q` unchanged.
- R3: With the bank enabled and empty, a report is captured at the next edge with this layout:
  - bit 63 set to 1 (valid)
  - bit 62 cleared to 0 (overflow)
  - bit 61 set to the uncorrected flag
  - bits [54:53] set to the health colour
  - bits [31:16] set to the model-specific code
  - bits [15:0] set to the architectural code
  - all other bits except 60 zero
- R4: A report that arrives while an uncorrected report is held sets bit 62. Bits 61, [54:53], [31:16] and [15:0] keep the first report, including the model-specific code.
- R5: An uncorrected report replaces a held corrected report in every field and sets bit 62.
- R6: A corrected report never replaces a held uncorrected report (bit 61 stays 1).
- R7: A held corrected report with yellow colour (10) is not replaced by a corrected report with colour 00 (untracked) or 01 (green). Bit 62 is still set.
- R8: A corrected report replaces a held corrected report when its colour code is equal to or greater than the held one. Bit 62 is set.
- R9: A software write of zero clears bits 63, 62, 61, [54:53], [31:16] and [15:0] in one cycle. Enable is kept.
- R10: In a cycle where a report arrives, the software write is ignored and the report is handled as if no write were present.
- R11: A nonzero software write copies only its bit 60 into the enable flag. All other bits are left unchanged.
- R12: `req_pulse` is high for exactly the cycle after a report is captured, and only when that report is uncorrected or has colour 10. It stays low after an overflow-only event or after a non-yellow corrected capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_vld | input | 1 | Report strobe, one cycle per report |
| err_msc | input | 16 | Model-specific code of the report |
| err_arc | input | 16 | Architectural code of the report |
| err_unc | input | 1 | 1 for uncorrected, 0 for corrected |
| err_health | input | 2 | Health colour: 00 untracked, 01 green, 10 yellow |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data |
| status_q | output | 64 | Status word |
| req_pulse | output | 1 | Registered request pulse |

## Verification
The bench builds the bank with its default 16-bit model-specific and architectural code widths. These are the widths that place the codes at bits [31:16] and [15:0], so every field position in the requirements is observed at the ports. Distinct code values per report show which report survived each arbitration. All severity pairings are driven, along with colour orderings above, equal to and below the held colour, and clear writes that collide with reports.

// File: rtl/mc_bank_pkg.sv
package mc_bank_pkg;
  localparam int VAL_B = 63;
  localparam int OVR_B = 62;
  localparam int UNC_B = 61;
  localparam int ENA_B = 60;
  localparam int HL_LO = 53;

  typedef enum logic [1:0] {
    HL_NONE   = 2'b00,
    HL_GREEN  = 2'b01,
    HL_YELLOW = 2'b10,
    HL_RSVD   = 2'b11
  } health_e;
endpackage

// File: rtl/mc_bank_arb.sv
module mc_bank_arb (
  input  logic        held_vld,
  input  logic        held_unc,
  input  logic [1:0]  held_hl,
  input  logic        ena,
  input  logic        new_vld,
  input  logic        new_unc,
  input  logic [1:0]  new_hl,
  output logic        do_log,
  output logic        do_ovr
);
  logic accept;

  always_comb begin
    accept = new_vld && ena;
    do_log = 1'b0;
    do_ovr = 1'b0;
    if (accept) begin
      if (!held_vld) begin
        do_log = 1'b1;
      end else begin
        do_ovr = 1'b1;
        if (held_unc) do_log = 1'b0;
        else if (new_unc) do_log = 1'b1;
        else do_log = (new_hl >= held_hl);
      end
    end
  end
endmodule

// File: rtl/mc_bank_store.sv
module mc_bank_store #(
  parameter int MSC_W = 16,
  parameter int ARC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_log,
  input  logic             do_ovr,
  input  logic             rpt_busy,
  input  logic             new_unc,
  input  logic [1:0]       new_hl,
  input  logic [MSC_W-1:0] new_msc,
  input  logic [ARC_W-1:0] new_arc,
  input  logic             sw_wr,
  input  logic [63:0]      sw_wdata,
  output logic             vld_q,
  output logic             ovr_q,
  output logic             unc_q,
  output logic             ena_q,
  output logic [1:0]       hl_q,
  output logic [MSC_W-1:0] msc_q,
  output logic [ARC_W-1:0] arc_q
);
  import mc_bank_pkg::*;

  logic sw_clear, sw_ena;

  assign sw_clear = sw_wr && !rpt_busy && (sw_wdata == 64'd0);
  assign sw_ena   = sw_wr && !rpt_busy && (sw_wdata != 64'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ovr_q <= 1'b0;
      unc_q <= 1'b0;
      ena_q <= 1'b0;
      hl_q  <= HL_NONE;
      msc_q <= '0;
      arc_q <= '0;
    end else begin
      if (do_log) begin
        vld_q <= 1'b1;
        unc_q <= new_unc;
        hl_q  <= new_hl;
        msc_q <= new_msc;
        arc_q <= new_arc;
      end else if (sw_clear) begin
        vld_q <= 1'b0;
        unc_q <= 1'b0;
        hl_q  <= HL_NONE;
        msc_q <= '0;
        arc_q <= '0;
      end
      if (do_ovr) ovr_q <= 1'b1;
      else if (sw_clear) ovr_q <= 1'b0;
      if (sw_ena) ena_q <= sw_wdata[ENA_B];
    end
  end
endmodule

// File: rtl/mc_bank_req.sv
module mc_bank_req (
  input  logic       clk,
  input  logic       rst,
  input  logic       do_log,
  input  logic       new_unc,
  input  logic [1:0] new_hl,
  output logic       req_q
);
  import mc_bank_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= do_log && (new_unc || (new_hl == HL_YELLOW));
  end
endmodule

// File: rtl/mc_err_bank.sv
module mc_err_bank #(
  parameter int MSC_W = 16,
  parameter int ARC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_vld,
  input  logic [MSC_W-1:0] err_msc,
  input  logic [ARC_W-1:0] err_arc,
  input  logic             err_unc,
  input  logic [1:0]       err_health,
  input  logic             sw_wr,
  input  logic [63:0]      sw_wdata,
  output logic [63:0]      status_q,
  output logic             req_pulse
);
  import mc_bank_pkg::*;

  localparam int CODE_W = MSC_W + ARC_W;
  localparam int GAP_W  = HL_LO - CODE_W;

  logic             vld_q, ovr_q, unc_q, ena_q;
  logic [1:0]       hl_q;
  logic [MSC_W-1:0] msc_q;
  logic [ARC_W-1:0] arc_q;
  logic             do_log, do_ovr;

  mc_bank_arb u_arb (
    .held_vld (vld_q),
    .held_unc (unc_q),
    .held_hl  (hl_q),
    .ena      (ena_q),
    .new_vld  (err_vld),
    .new_unc  (err_unc),
    .new_hl   (err_health),
    .do_log   (do_log),
    .do_ovr   (do_ovr)
  );

  mc_bank_store #(.MSC_W(MSC_W), .ARC_W(ARC_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .do_log   (do_log),
    .do_ovr   (do_ovr),
    .rpt_busy (err_vld),
    .new_unc  (err_unc),
    .new_hl   (err_health),
    .new_msc  (err_msc),
    .new_arc  (err_arc),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .vld_q    (vld_q),
    .ovr_q    (ovr_q),
    .unc_q    (unc_q),
    .ena_q    (ena_q),
    .hl_q     (hl_q),
    .msc_q    (msc_q),
    .arc_q    (arc_q)
  );

  mc_bank_req u_req (
    .clk     (clk),
    .rst     (rst),
    .do_log  (do_log),
    .new_unc (err_unc),
    .new_hl  (err_health),
    .req_q   (req_pulse)
  );

  assign status_q = {vld_q, ovr_q, unc_q, ena_q, 5'd0, hl_q,
                     {GAP_W{1'b0}}, msc_q, arc_q};
endmodule

// File: rtl/mc_err_bank_chk.sv
module mc_err_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        err_vld,
  input logic        sw_wr,
  input logic [63:0] sw_wdata,
  input logic [63:0] status_q,
  input logic        req_pulse
);
  // R2
  a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
    (err_vld && !status_q[60]) |=> $stable(status_q));

  // R3
  a_r3_first_capture: assert property (@(posedge clk) disable iff (rst)
    (err_vld && status_q[60] && !status_q[63]) |=> (status_q[63] && !status_q[62]));

  // R4
  a_r4_uc_fields_kept: assert property (@(posedge clk) disable iff (rst)
    (err_vld && status_q[60] && status_q[63] && status_q[61])
      |=> (status_q[62] && status_q[31:0] == $past(status_q[31:0])
           && status_q[54:53] == $past(status_q[54:53])));

  // R6
  a_r6_uc_sticks: assert property (@(posedge clk) disable iff (rst)
    (err_vld && status_q[63] && status_q[61]) |=> status_q[61]);

  // R9
  a_r9_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && sw_wdata == 64'd0 && !err_vld)
      |=> (status_q[63:61] == 3'b000 && status_q[59:0] == 60'd0));

  // R12
  a_r12_req_cause: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> (status_q[63] && (status_q[61] || status_q[54:53] == 2'b10)));
endmodule

bind mc_err_bank mc_err_bank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .err_vld   (err_vld),
  .sw_wr     (sw_wr),
  .sw_wdata  (sw_wdata),
  .status_q  (status_q),
  .req_pulse (req_pulse)
);

// File: tb/mc_err_bank_test.sv
`timescale 1ns/100ps
module mc_err_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_vld = 1'b0;
  logic [15:0] err_msc = '0;
  logic [15:0] err_arc = '0;
  logic        err_unc = 1'b0;
  logic [1:0]  err_health = 2'b00;
  logic        sw_wr = 1'b0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] status_q;
  logic        req_pulse;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [63:0] st;
    logic        rq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench-side expectation of the bank contents
  logic        mv = 0, mo = 0, mu = 0, me = 0;
  logic [1:0]  mh = 0;
  logic [15:0] mm = 0, ma = 0;

  always #2.5 clk = ~clk;

  mc_err_bank uut (
    .clk(clk), .rst(rst), .err_vld(err_vld), .err_msc(err_msc),
    .err_arc(err_arc), .err_unc(err_unc), .err_health(err_health),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .status_q(status_q),
    .req_pulse(req_pulse)
  );

  function automatic logic [63:0] pack();
    return {mv, mo, mu, me, 5'd0, mh, 21'd0, mm, ma};
  endfunction

  task automatic step(input logic v, input logic u, input logic [1:0] h,
                      input logic [15:0] msc, input logic [15:0] arc,
                      input logic w, input logic [63:0] wd, input string tag);
    exp_t e;
    logic rq;
    @(negedge clk);
    err_vld = v; err_unc = u; err_health = h; err_msc = msc; err_arc = arc;
    sw_wr = w; sw_wdata = wd;
    rq = 1'b0;
    if (v) begin
      if (me) begin
        logic take;
        take = 1'b0;
        if (!mv) take = 1'b1;
        else begin
          mo = 1'b1;
          if (mu) take = 1'b0;
          else if (u) take = 1'b1;
          else take = (h >= mh);
        end
        if (take) begin
          mv = 1'b1; mu = u; mh = h; mm = msc; ma = arc;
          rq = u || (h == 2'b10);
        end
      end
    end else if (w) begin
      if (wd == 64'd0) begin
        mv = 0; mo = 0; mu = 0; mh = 0; mm = 0; ma = 0;
      end else me = wd[60];
    end
    e.st = pack(); e.rq = rq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    err_vld = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 2'b00, 16'h0, 16'h0, 0, 64'h0, tag);
  endtask

  // monitor: compare one expectation per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (status_q !== e.st || req_pulse !== e.rq) begin
          n_bad++;
          $display("FAIL %s: status=%h req=%b expected status=%h req=%b",
                   e.tag, status_q, req_pulse, e.st, e.rq);
        end
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    n_chk++;
    if (status_q !== 64'd0 || req_pulse !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: status=%h req=%b expected status=0 req=0", status_q, req_pulse);
    end
    // R2: disabled bank ignores reports
    step(1, 1, 2'b10, 16'hAAAA, 16'h5555, 0, 64'h0, "R2");
    // R11: nonzero write sets enable only
    step(0, 0, 2'b00, 16'h0, 16'h0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
    // R3: first capture, corrected green, no request
    step(1, 0, 2'b01, 16'h1234, 16'h0115, 0, 64'h0, "R3");
    idle("R12");
    // R8: equal colour replaces
    step(1, 0, 2'b01, 16'h2222, 16'h0111, 0, 64'h0, "R8");
    // R8: yellow replaces green, request raised
    step(1, 0, 2'b10, 16'h3333, 16'h0125, 0, 64'h0, "R8");
    idle("R12");
    // R7: green and untracked do not replace yellow
    step(1, 0, 2'b01, 16'h4444, 16'h0101, 0, 64'h0, "R7");
    step(1, 0, 2'b00, 16'h4545, 16'h0105, 0, 64'h0, "R7");
    // R5: uncorrected replaces corrected
    step(1, 1, 2'b00, 16'h5A5A, 16'h0150, 0, 64'h0, "R5");
    // R4: second uncorrected keeps first fields
    step(1, 1, 2'b10, 16'h6B6B, 16'h0999, 0, 64'h0, "R4");
    // R6: corrected never replaces uncorrected
    step(1, 0, 2'b10, 16'h7C7C, 16'h0888, 0, 64'h0, "R6");
    // R10: report wins over simultaneous clear
    step(1, 0, 2'b00, 16'h8D8D, 16'h0777, 1, 64'h0, "R10");
    // R9: clear
    step(0, 0, 2'b00, 16'h0, 16'h0, 1, 64'h0, "R9");
    // R3 after clear, uncorrected capture with request
    step(1, 1, 2'b01, 16'hBEEF, 16'hCAFE, 0, 64'h0, "R3");
    idle("R12");
    step(0, 0, 2'b00, 16'h0, 16'h0, 1, 64'h0, "R9");
    // R10: report into empty bank with clear in same cycle
    step(1, 0, 2'b10, 16'h0F0F, 16'h0321, 1, 64'h0, "R10");
    // R11: disable via write, then report ignored
    step(0, 0, 2'b00, 16'h0, 16'h0, 1, 64'h0000_0000_0000_0001, "R11");
    step(1, 1, 2'b10, 16'h1111, 16'h2222, 0, 64'h0, "R2");
    idle("R12");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule